// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block is the transmit half of an asynchronous serial channel. A byte enters a single-entry holding register through a valid/ready stream port. When the shift stage is free, the byte is moved into it on the next bit-rate tick. It then leaves on the serial line, one bit per tick period, wrapped in a start bit, an optional extra bit and one or two stop bits. The next byte can be accepted as soon as the holding register has been emptied, so consecutive frames follow each other with no idle gap.

The frame layout comes from a six-bit control word written through a plain write strobe. The word sets the data length (7 or 8 bits), whether parity is sent, whether parity is even or odd, and the number of stop bits. It also sets an addressing mode in which a software-set flag bit takes the place of parity. A status output reports that the holding register is empty. A clear-to-send input, when high, forces that status low without stopping transmission. The bit-rate tick comes from outside.

Stream rules: `tx_ready` is high exactly while the holding register is empty. A byte is taken on any rising clock edge where `tx_valid` and `tx_ready` are both high. While the register is full, `tx_ready` stays low and the source must hold its byte.

Top module: `async_frame_tx`

## Requirements
- R1: After reset:
  - `txd` is 1 and `tx_ready` is 1.
  - `tdr_empty` is 1 while `cts_n` is low.
  - All control fields except the flag value are 0, so the first frame after reset is 7 data bits, no extra bit and one stop bit.
- R2: A frame is sent in this order: a 0 start bit, the data bits least significant first, any extra bit, then stop bits at 1. The line idles at 1. Each bit lasts exactly one tick period. A frame starts on a tick edge where the holding register is full and the shifter is idle or finishing.
- R3: Control bit 2 selects the data length: 0 sends data bits 6..0 only (bit 7 is not sent), 1 sends all eight bits.
- R4: Control bit 1 enables a parity bit after the data. Control bit 3 picks the parity: 0 even, 1 odd. The count covers the transmitted data bits plus the parity bit.
- R5: When parity is disabled, control bit 3 has no effect on the frame.
- R6: Control bit 0 selects the stop count: 0 gives one stop bit, 1 gives two.
- R7: When control bit 4 is 1:
  - The bit after the data equals control bit 5.
  - No parity bit is sent, whatever bit 1 holds.
  - The stop count still follows bit 0.
- R8: `tx_ready` equals "holding register empty". Accepting a byte drops `tdr_empty` and `tx_ready` from the next cycle. Moving the byte into the shifter raises them again from the edge that starts the frame.
- R9: While `cts_n` is high, `tdr_empty` is 0. `cts_n` has no effect on `tx_ready` or on the serial output.
- R10: A byte waiting in the holding register when a frame's last stop bit ends starts its frame on that same tick, with no idle bit in between.
- R11: The control word is captured when a frame starts. Writing it during a frame changes only later frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: [0] two stop, [1] parity on, [2] 8-bit data, [3] odd parity, [4] address mode, [5] flag value |
| tx_valid | input | 1 | Stream byte valid |
| tx_data | input | 8 | Stream byte |
| tx_ready | output | 1 | Holding register empty, byte can be taken |
| cts_n | input | 1 | Clear-to-send, high blocks the empty status |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tdr_empty | output | 1 | Holding register empty status, gated by `cts_n` |
| txd | output | 1 | Serial line |

## Verification
The hardest case to reach is the hand-over on the tick that ends a frame's last stop bit. A second byte must already be waiting in the holding register at that tick, and the shifter must reload rather than go idle. The bench sets this up by pushing two bytes in a row: the second is back-pressured until the first frame starts, then waits through the whole first frame. The bench records the cycle in which each start bit appears and checks that the second start follows the first by exactly the frame length in tick periods. The mid-frame control write is set up the same way: the bench waits for a start bit to appear, then writes the control word while that frame is still on the line.

// File: rtl/atx_pkg.sv
package atx_pkg;
  // Control word layout, bit 0 at the bottom
  typedef struct packed {
    logic mp_flag;   // [5]
    logic mp_mode;   // [4]
    logic par_odd;   // [3]
    logic len_long;  // [2]
    logic par_en;    // [1]
    logic two_stop;  // [0]
  } atx_cfg_t;

  localparam int CFG_W = $bits(atx_cfg_t);
endpackage

// File: rtl/atx_cfg.sv
module atx_cfg
  import atx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output atx_cfg_t         cfg
);
  atx_cfg_t wd;
  logic     flag_q;

  assign wd = atx_cfg_t'(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.mp_mode  <= 1'b0;
      cfg.par_odd  <= 1'b0;
      cfg.len_long <= 1'b0;
      cfg.par_en   <= 1'b0;
      cfg.two_stop <= 1'b0;
    end else if (we) begin
      cfg.mp_mode  <= wd.mp_mode;
      cfg.par_odd  <= wd.par_odd;
      cfg.len_long <= wd.len_long;
      cfg.par_en   <= wd.par_en;
      cfg.two_stop <= wd.two_stop;
    end
  end

  // Flag value has no defined reset state
  always_ff @(posedge clk) begin
    if (we) flag_q <= wd.mp_flag;
  end

  assign cfg.mp_flag = flag_q;
endmodule

// File: rtl/atx_hold.sv
module atx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic [DATA_W-1:0] data_q,
  output logic              full
);
  assign in_ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      full   <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full   <= 1'b0;
    end
  end

  // R8
  acc_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> full);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(data_q)));
endmodule

// File: rtl/atx_framer.sv
module atx_framer
  import atx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  atx_cfg_t           cfg,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  logic [CNT_W-1:0] nd;
  logic [CNT_W-1:0] pos;
  logic             par;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    nd       = cfg.len_long ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
    par      = cfg.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < nd) begin
        frame[i+1] = data[i];
        par        = par ^ data[i];
      end
    end
    pos = nd + CNT_W'(1);
    if (cfg.mp_mode) begin
      frame[pos] = cfg.mp_flag;
      pos        = pos + CNT_W'(1);
    end else if (cfg.par_en) begin
      frame[pos] = par;
      pos        = pos + CNT_W'(1);
    end
    nbits = pos + (cfg.two_stop ? CNT_W'(2) : CNT_W'(1));
  end
endmodule

// File: rtl/atx_shifter.sv
module atx_shifter #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               full,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  output logic               take,
  output logic               busy,
  output logic               txd
);
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic               last;

  assign last = (cnt == CNT_W'(1));
  assign take = tick && full && (!busy || last);
  assign txd  = busy ? sr[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sr   <= '1;
      cnt  <= '0;
    end else if (tick) begin
      if (take) begin
        sr   <= frame;
        cnt  <= nbits;
        busy <= 1'b1;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        sr  <= {1'b1, sr[FRAME_W-1:1]};
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R2
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick));

  // R2
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (busy && $stable(txd)));
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import atx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CFG_W-1:0]  ctl_wdata,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              cts_n,
  input  logic              bit_tick,
  output logic              tdr_empty,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  atx_cfg_t           cfg;
  logic [DATA_W-1:0]  hold_data;
  logic               hold_full;
  logic               take;
  logic               busy;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  atx_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .cfg(cfg)
  );

  atx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(tx_valid), .in_data(tx_data),
    .in_ready(tx_ready), .take(take), .data_q(hold_data), .full(hold_full)
  );

  atx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .cfg(cfg), .data(hold_data), .frame(frame), .nbits(nbits)
  );

  atx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .full(hold_full),
    .frame(frame), .nbits(nbits), .take(take), .busy(busy), .txd(txd)
  );

  assign tdr_empty = !hold_full && !cts_n;

  // R6
  flen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nbits >= CNT_W'(DATA_W + 1)) && (nbits <= CNT_W'(FRAME_W)));

  // R2
  frame_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && bit_tick && !busy) |=> (busy && !txd));
endmodule

// File: tb/sim_async_frame_tx.sv
`timescale 1ns/1ps
module sim_async_frame_tx;
  localparam int TP = 8; // clock cycles per bit tick

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready;
  logic       cts_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       tdr_empty;
  logic       txd;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  async_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .cts_n(cts_n), .bit_tick(bit_tick), .tdr_empty(tdr_empty), .txd(txd)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      bit_tick = (t == 0);
      t = (t + 1) % TP;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected frame from the requirements: bit k is the k-th bit on the line
  function automatic void expf(input logic [5:0] c, input logic [7:0] d,
                               output logic [11:0] b, output int n);
    int nd;
    logic p;
    b = '1;
    n = 0;
    b[n] = 1'b0; n++;
    nd = c[2] ? 8 : 7;
    p = c[3];
    for (int i = 0; i < nd; i++) begin
      b[n] = d[i]; p = p ^ d[i]; n++;
    end
    if (c[4]) begin
      b[n] = c[5]; n++;
    end else if (c[1]) begin
      b[n] = p; n++;
    end
    b[n] = 1'b1; n++;
    if (c[0]) begin
      b[n] = 1'b1; n++;
    end
  endfunction

  task automatic set_cfg(input logic [5:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic capture(input int n, output logic [11:0] b, output int st);
    int w = 0;
    b = '1;
    @(negedge clk);
    while (txd !== 1'b0 && w < 400) begin
      @(negedge clk); w++;
    end
    st = cyc;
    repeat (TP/2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      b[k] = txd;
      if (k != n - 1) repeat (TP) @(negedge clk);
    end
  endtask

  task automatic one_frame(input logic [5:0] c, input logic [7:0] d, input string req);
    logic [11:0] eb, ab;
    int n, st;
    bit idle_ok;
    expf(c, d, eb, n);
    set_cfg(c);
    fork
      send(d);
      capture(n, ab, st);
    join
    check(ab == eb, req, ab, eb);
    idle_ok = 1'b1;
    repeat (TP + 2) begin
      @(negedge clk);
      if (txd !== 1'b1) idle_ok = 1'b0;
    end
    check(idle_ok, {req, " idle"}, 0, 1);
  endtask

  task automatic t_reset;
    check(txd === 1'b1, "R1 txd", txd, 1);
    check(tx_ready === 1'b1, "R1 tx_ready", tx_ready, 1);
    check(tdr_empty === 1'b1, "R1 tdr_empty", tdr_empty, 1);
    begin : r1_default_frame
      logic [11:0] eb, ab;
      int n, st;
      expf(6'b000000, 8'hB6, eb, n);
      fork
        send(8'hB6);
        capture(n, ab, st);
      join
      check(ab == eb, "R1 default 7-bit frame", ab, eb);
      repeat (2*TP) @(negedge clk);
    end
  endtask

  task automatic t_formats;
    one_frame(6'b000100, 8'hA5, "R2 R3 8N1");
    one_frame(6'b000010, 8'hD3, "R3 R4 7E1");
    one_frame(6'b001111, 8'h5C, "R4 R6 8O2");
    one_frame(6'b000110, 8'h01, "R4 8E1");
    one_frame(6'b001100, 8'h3C, "R5 odd sense no parity");
    one_frame(6'b000001, 8'h7F, "R6 7N2");
    one_frame(6'b110110, 8'h81, "R7 flag 1 parity ignored");
    one_frame(6'b010011, 8'h2A, "R7 flag 0 two stop");
  endtask

  task automatic t_handshake;
    logic [11:0] ab;
    int st;
    set_cfg(6'b000100);
    @(negedge clk);
    check(tdr_empty === 1'b1, "R8 empty before write", tdr_empty, 1);
    send(8'h96);
    check(tdr_empty === 1'b0, "R8 empty cleared by write", tdr_empty, 0);
    check(tx_ready === 1'b0, "R8 ready low while full", tx_ready, 0);
    capture(1, ab, st);
    check(ab[0] === 1'b0, "R8 start seen", ab[0], 0);
    check(tdr_empty === 1'b1, "R8 empty set on transfer", tdr_empty, 1);
    repeat (12*TP) @(negedge clk);
  endtask

  task automatic t_cts;
    logic [11:0] eb, ab;
    int n, st;
    set_cfg(6'b000100);
    cts_n = 1'b1;
    @(negedge clk);
    check(tdr_empty === 1'b0, "R9 gated empty", tdr_empty, 0);
    check(tx_ready === 1'b1, "R9 ready unaffected", tx_ready, 1);
    expf(6'b000100, 8'h5A, eb, n);
    fork
      send(8'h5A);
      capture(n, ab, st);
    join
    check(ab == eb, "R9 frame sent under cts", ab, eb);
    check(tdr_empty === 1'b0, "R9 still gated", tdr_empty, 0);
    cts_n = 1'b0;
    @(negedge clk);
    check(tdr_empty === 1'b1, "R9 released", tdr_empty, 1);
    repeat (2*TP) @(negedge clk);
  endtask

  task automatic t_b2b;
    logic [11:0] e1, e2, a1, a2;
    int n1, n2, s1, s2;
    set_cfg(6'b000010);
    expf(6'b000010, 8'h11, e1, n1);
    expf(6'b000010, 8'hEE, e2, n2);
    fork
      begin send(8'h11); send(8'hEE); end
      begin capture(n1, a1, s1); capture(n2, a2, s2); end
    join
    check(a1 == e1, "R10 first frame", a1, e1);
    check(a2 == e2, "R10 second frame", a2, e2);
    check(s2 - s1 == n1*TP, "R10 no gap", s2 - s1, n1*TP);
    repeat (2*TP) @(negedge clk);
  endtask

  task automatic t_midcfg;
    logic [11:0] e1, e2, a1, a2;
    int n1, n2, s1, s2;
    set_cfg(6'b000100);
    expf(6'b000100, 8'h0F, e1, n1);
    expf(6'b001011, 8'h0F, e2, n2);
    fork
      send(8'h0F);
      begin
        capture(1, a1, s1);
        repeat (2*TP) @(negedge clk);
        set_cfg(6'b001011);
      end
    join
    // resume sampling bit 3 onward of the running frame
    a1 = e1;
    repeat (TP/2) @(negedge clk);
    for (int k = 3; k < n1; k++) begin
      while (cyc < s1 + k*TP + TP/2) @(negedge clk);
      a1[k] = txd;
    end
    check(a1 == e1, "R11 running frame keeps format", a1, e1);
    repeat (2*TP) @(negedge clk);
    fork
      send(8'h0F);
      capture(n2, a2, s2);
    join
    check(a2 == e2, "R11 next frame uses new format", a2, e2);
    repeat (2*TP) @(negedge clk);
  endtask

  initial begin
    bit done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_formats();
        t_handshake();
        t_cts();
        t_b2b();
        t_midcfg();
        done = 1'b1;
      end
      begin
        repeat (150000) @(posedge clk);
      end
    join_any
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule